// File: doc/BRIEF.md
# FEAC Code Word Receive Detector

This block watches the far-end alarm and control channel of a DS3 receiver, which arrives as one bit per frame together with a strobe once the C-bit parity overhead has been pulled out upstream. It searches the bit stream for complete 16-bit FEAC code word patterns and extracts the 6-bit message field from each one. It then declares a valid message and latches it for a host.

There are two ways to declare a message. In single-code mode, one pattern is enough. In multiple-code mode, a validation state machine keeps a tentative code, an alternative code and a saturating 4-bit repetition count, and it declares only once enough matching repetitions have been seen. Outside C-bit parity framing the channel has no meaning, so the block is held idle there.

A declaration raises a one-cycle pulse, loads the code into an output register and sets a sticky status flag. A host read clears the flag and starts validation again.

Top module: `feac_rx_detector`

## Requirements
- R1: A pattern is found on a bit strobe when the last 16 strobed bits, in arrival order, are eight 1s, then a 0, then six message bits, then a 0. The first message bit to arrive is bit 0 of the code. A pattern may start after any number of leading bits.
- R2: An all-1s stream never yields a pattern. After a pattern is found, the next pattern must be made entirely of 16 newly strobed bits.
- R3: The block acts only when frame_mode is 2'b00 (C-bit parity). For any other value, strobes are ignored and validation returns to its initial state with both code registers cleared.
- R4: With multi_sel=0 (single-code mode), the first pattern is declared as a valid message.
- R5: With multi_sel=1, the first pattern loads the tentative code with a count of 1. At the tentative compare step, a matching pattern adds 1 to the count. A count of 9 or more declares the tentative code, so nine identical patterns declare on the ninth.
- R6: At the tentative compare step, a mismatching pattern is stored as the alternative code and moves to the dual compare step. There, a match with the tentative code adds 2 to the count, followed by the same termination check.
- R7: At the dual compare step, a pattern that matches only the alternative code promotes the alternative to tentative, sets the count to 2 and returns to the tentative compare step.
- R8: At the dual compare step, a pattern that matches neither code promotes the alternative to tentative, sets the count to 1, stores the new code as the alternative and stays at the dual compare step.
- R9: A declaration produces the following on the same clock edge, which is the second rising edge counting the edge that samples the completing strobe: valid_pulse high for one cycle, code_out loaded, and status_valid set. All three outputs are 0 after reset.
- R10: After a declaration, further patterns are ignored and code_out is held. A host_rd pulse clears status_valid and restarts validation, and it leaves code_out unchanged.
- R11: Any change of multi_sel restarts validation from the initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_mode | input | 2 | Framing format; 2'b00 = C-bit parity, other values disable |
| multi_sel | input | 1 | 0 = single-code mode, 1 = multiple-code mode |
| fe_bit_stb | input | 1 | Qualifies fe_bit for one cycle |
| fe_bit | input | 1 | FEAC channel bit |
| host_rd | input | 1 | Host read strobe; clears status and restarts validation |
| valid_pulse | output | 1 | One-cycle pulse on a declaration |
| code_out | output | 6 | Last declared message code |
| status_valid | output | 1 | Sticky flag showing a message was declared |

## Verification
The locator registers its pattern hit on the edge that samples the completing strobe. The validator's declaration is registered one edge later, so valid_pulse, code_out and status_valid all change on the second rising edge. The bench drives each strobe between falling edges and pushes the expected code into the scoreboard queue from its own model as soon as the last strobe of a word has been sampled. A monitor reads the outputs on every falling edge and pops one entry for each pulse. Each word is followed by several idle cycles, so every pulse has been matched before the next word begins. Checks that a stimulus was ignored, and checks of the status flag and held code after a host read, are sampled a few cycles after the stimulus, when any response would already be visible.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;

    localparam int WORD_W  = 16;
    localparam int ONES_W  = 8;
    localparam int CODE_W  = 6;
    localparam int CNT_W   = 4;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [1:0]        fmode_t;

    localparam fmode_t FMODE_CBIT = 2'b00;

    typedef enum logic [1:0] {
        V_INIT = 2'd0,
        V_TENT = 2'd1,
        V_DUAL = 2'd2,
        V_DONE = 2'd3
    } vstate_e;

    typedef struct packed {
        logic  hit;
        code_t code;
    } pat_s;

    // oldest bit sits at index 0
    function automatic logic is_pattern(word_t w);
        return (w[ONES_W-1:0] == '1) && !w[ONES_W] && !w[WORD_W-1];
    endfunction

    function automatic code_t field_of(word_t w);
        return w[ONES_W+1 +: CODE_W];
    endfunction

    function automatic cnt_t sat_add(cnt_t a, cnt_t b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? '1 : s[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/feac_bit_locator.sv
module feac_bit_locator
    import feac_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic stb,
    input  logic din,
    output pat_s pat_o
);
    word_t sr;
    word_t sr_next;

    assign sr_next = {din, sr[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sr    <= '0;
            pat_o <= '0;
        end else begin
            pat_o.hit <= 1'b0;
            if (stb) begin
                if (is_pattern(sr_next)) begin
                    pat_o.hit  <= 1'b1;
                    pat_o.code <= field_of(sr_next);
                    sr         <= '0;   // zero at index 0 forces 16 fresh bits
                end else begin
                    sr <= sr_next;
                end
            end
        end
    end

    a_r1_hit_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        pat_o.hit |-> $past(stb));

    a_r3_no_hit_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pat_o.hit);

endmodule

// File: rtl/feac_code_validator.sv
module feac_code_validator
    import feac_rx_pkg::*;
#(
    parameter int VALID_COUNT = 9
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  multi,
    input  logic  host_rd,
    input  pat_s  pat_i,
    output logic  fire,
    output code_t fire_code
);
    localparam cnt_t THR = CNT_W'(VALID_COUNT);
    localparam cnt_t ONE = CNT_W'(1);
    localparam cnt_t TWO = CNT_W'(2);

    vstate_e st, st_n;
    code_t   tent, tent_n, alt, alt_n;
    cnt_t    cnt, cnt_n, sum;
    logic    multi_q;
    logic    restart;

    assign restart = !en || host_rd || (multi != multi_q);

    always_comb begin
        st_n      = st;
        tent_n    = tent;
        alt_n     = alt;
        cnt_n     = cnt;
        sum       = '0;
        fire      = 1'b0;
        fire_code = tent;
        if (restart) begin
            st_n   = V_INIT;
            tent_n = '0;
            alt_n  = '0;
            cnt_n  = '0;
        end else if (pat_i.hit) begin
            case (st)
                V_INIT: begin
                    if (!multi) begin
                        fire      = 1'b1;
                        fire_code = pat_i.code;
                        st_n      = V_DONE;
                    end else begin
                        tent_n = pat_i.code;
                        cnt_n  = ONE;
                        st_n   = V_TENT;
                    end
                end
                V_TENT: begin
                    if (pat_i.code == tent) begin
                        sum   = sat_add(cnt, ONE);
                        cnt_n = sum;
                        if (sum >= THR) begin
                            fire = 1'b1;
                            st_n = V_DONE;
                        end
                    end else begin
                        alt_n = pat_i.code;
                        st_n  = V_DUAL;
                    end
                end
                V_DUAL: begin
                    if (pat_i.code == tent) begin
                        sum   = sat_add(cnt, TWO);
                        cnt_n = sum;
                        st_n  = (sum >= THR) ? V_DONE : V_TENT;
                        fire  = (sum >= THR);
                    end else if (pat_i.code == alt) begin
                        tent_n = alt;
                        cnt_n  = TWO;
                        st_n   = V_TENT;
                    end else begin
                        tent_n = alt;
                        alt_n  = pat_i.code;
                        cnt_n  = ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= V_INIT;
            tent    <= '0;
            alt     <= '0;
            cnt     <= '0;
            multi_q <= 1'b0;
        end else begin
            st      <= st_n;
            tent    <= tent_n;
            alt     <= alt_n;
            cnt     <= cnt_n;
            multi_q <= multi;
        end
    end

    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (st == V_DONE && !restart) |=> st == V_DONE);

    a_r6_count_window: assert property (@(posedge clk) disable iff (rst)
        (st == V_TENT || st == V_DUAL) |-> (cnt >= ONE && cnt < THR));

    a_r3_off_restarts: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == V_INIT && tent == '0 && alt == '0));

    a_r11_mode_change_restarts: assert property (@(posedge clk) disable iff (rst)
        (multi != multi_q) |=> st == V_INIT);

endmodule

// File: rtl/feac_result_reg.sv
module feac_result_reg
    import feac_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  code_t fire_code,
    input  logic  host_rd,
    output logic  pulse,
    output code_t code_q,
    output logic  sticky
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            code_q <= '0;
            sticky <= 1'b0;
        end else begin
            pulse <= fire;
            if (fire) begin
                code_q <= fire_code;
                sticky <= 1'b1;
            end else if (host_rd) begin
                sticky <= 1'b0;
            end
        end
    end

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !fire) |=> !sticky);

endmodule

// File: rtl/feac_rx_detector.sv
module feac_rx_detector
    import feac_rx_pkg::*;
#(
    parameter int VALID_COUNT = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  frame_mode,
    input  logic        multi_sel,
    input  logic        fe_bit_stb,
    input  logic        fe_bit,
    input  logic        host_rd,
    output logic        valid_pulse,
    output logic [5:0]  code_out,
    output logic        status_valid
);
    logic  en;
    pat_s  pat;
    logic  fire;
    code_t fire_code;

    assign en = (frame_mode == FMODE_CBIT);

    feac_bit_locator u_loc (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .stb   (fe_bit_stb),
        .din   (fe_bit),
        .pat_o (pat)
    );

    feac_code_validator #(.VALID_COUNT(VALID_COUNT)) u_val (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .multi     (multi_sel),
        .host_rd   (host_rd),
        .pat_i     (pat),
        .fire      (fire),
        .fire_code (fire_code)
    );

    feac_result_reg u_res (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_code (fire_code),
        .host_rd   (host_rd),
        .pulse     (valid_pulse),
        .code_q    (code_out),
        .sticky    (status_valid)
    );

    a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
        valid_pulse |=> !valid_pulse);

    a_r9_status_with_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_pulse |-> status_valid);

    a_r10_code_held: assert property (@(posedge clk) disable iff (rst)
        !valid_pulse |-> $stable(code_out));

endmodule

// File: tb/tb_feac_rx_detector.sv
module tb_feac_rx_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] frame_mode = 2'b00;
    logic       multi_sel = 1'b0;
    logic       fe_bit_stb = 1'b0;
    logic       fe_bit = 1'b0;
    logic       host_rd = 1'b0;
    logic       valid_pulse;
    logic [5:0] code_out;
    logic       status_valid;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [5:0] exp_q[$];

    // reference model state
    int         m_st = 0;      // 0 init, 1 tentative, 2 dual, 3 done
    logic [5:0] m_tent, m_alt;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;    // 200 MHz

    feac_rx_detector dut (
        .clk(clk), .rst(rst), .frame_mode(frame_mode), .multi_sel(multi_sel),
        .fe_bit_stb(fe_bit_stb), .fe_bit(fe_bit), .host_rd(host_rd),
        .valid_pulse(valid_pulse), .code_out(code_out), .status_valid(status_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_restart();
        m_st = 0; m_tent = '0; m_alt = '0; m_cnt = 0;
    endfunction

    function automatic void m_declare(input logic [5:0] c);
        exp_q.push_back(c);
        m_st = 3;
    endfunction

    function automatic void m_pattern(input logic [5:0] c);
        if (frame_mode != 2'b00) return;
        case (m_st)
            0: if (!multi_sel) m_declare(c);
               else begin m_tent = c; m_cnt = 1; m_st = 1; end
            1: if (c == m_tent) begin
                   m_cnt += 1;
                   if (m_cnt >= 9) m_declare(m_tent);
               end else begin m_alt = c; m_st = 2; end
            2: if (c == m_tent) begin
                   m_cnt += 2;
                   if (m_cnt >= 9) m_declare(m_tent); else m_st = 1;
               end else if (c == m_alt) begin
                   m_tent = m_alt; m_cnt = 2; m_st = 1;
               end else begin
                   m_tent = m_alt; m_alt = c; m_cnt = 1;
               end
            default: ;
        endcase
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        fe_bit_stb = 1'b1;
        fe_bit     = b;
        @(negedge clk);
        fe_bit_stb = 1'b0;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    // R1 order: bit 0 of the word is sent first
    task automatic send_word(input logic [5:0] c);
        logic [15:0] w;
        w = {1'b0, c, 1'b0, 8'hFF};
        for (int i = 0; i < 16; i++) send_bit(w[i]);
        m_pattern(c);
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        m_restart();
    endtask

    task automatic set_multi(input logic v);
        @(negedge clk);
        multi_sel = v;
        m_restart();
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && valid_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected valid_pulse", int'(code_out), 0);
            end else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                chk(code_out == e, "R9 declared code", int'(code_out), int'(e));
                chk(status_valid == 1'b1, "R9 status with pulse", int'(status_valid), 1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_restart();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset values
        chk(valid_pulse == 0 && code_out == 0 && status_valid == 0, "R9 reset state",
            int'({valid_pulse, code_out, status_valid}), 0);

        // R4 / R1 single-code mode, pattern preceded by idle ones
        send_ones(5);
        send_word(6'h2A);
        chk(status_valid == 1, "R4 single declare status", int'(status_valid), 1);
        chk(code_out == 6'h2A, "R1 code field order", int'(code_out), 'h2A);

        // R10 patterns ignored after declaration, code held
        send_word(6'h15);
        chk(code_out == 6'h2A, "R10 code held while done", int'(code_out), 'h2A);
        host_read();
        @(negedge clk);
        chk(status_valid == 0, "R10 host read clears status", int'(status_valid), 0);
        chk(code_out == 6'h2A, "R10 code kept after read", int'(code_out), 'h2A);

        // R2 all-ones stream yields nothing
        send_ones(64);
        repeat (4) @(negedge clk);
        chk(status_valid == 0, "R2 all ones ignored", int'(status_valid), 0);

        // R3 other framing ignores patterns
        frame_mode = 2'b01;
        send_word(6'h07);
        chk(status_valid == 0, "R3 disabled framing ignored", int'(status_valid), 0);
        frame_mode = 2'b00;
        repeat (2) @(negedge clk);

        // R5 nine identical patterns
        set_multi(1'b1);
        for (int i = 0; i < 8; i++) send_word(6'h05);
        chk(status_valid == 0, "R5 no declare after eight", int'(status_valid), 0);
        send_word(6'h05);
        chk(status_valid == 1 && code_out == 6'h05, "R5 declare on ninth",
            int'(code_out), 'h05);
        host_read();

        // R6 A B A then A x6
        send_word(6'h11); send_word(6'h22); send_word(6'h11);
        for (int i = 0; i < 5; i++) send_word(6'h11);
        chk(status_valid == 0, "R6 count eight not declared", int'(status_valid), 0);
        send_word(6'h11);
        chk(status_valid == 1 && code_out == 6'h11, "R6 dual tentative adds two",
            int'(code_out), 'h11);
        host_read();

        // R7 A B B then B x7
        send_word(6'h01); send_word(6'h3C); send_word(6'h3C);
        for (int i = 0; i < 7; i++) send_word(6'h3C);
        chk(status_valid == 1 && code_out == 6'h3C, "R7 alternative promoted",
            int'(code_out), 'h3C);
        host_read();

        // R8 A B C C then C x7
        send_word(6'h0A); send_word(6'h0B); send_word(6'h0C); send_word(6'h0C);
        for (int i = 0; i < 6; i++) send_word(6'h0C);
        chk(status_valid == 0, "R8 no early declare", int'(status_valid), 0);
        send_word(6'h0C);
        chk(status_valid == 1 && code_out == 6'h0C, "R8 neither match shifts codes",
            int'(code_out), 'h0C);
        host_read();

        // R11 mode change restarts count
        for (int i = 0; i < 5; i++) send_word(6'h30);
        set_multi(1'b0);
        set_multi(1'b1);
        for (int i = 0; i < 8; i++) send_word(6'h30);
        chk(status_valid == 0, "R11 count restarted", int'(status_valid), 0);
        send_word(6'h30);
        chk(status_valid == 1 && code_out == 6'h30, "R11 declare after restart",
            int'(code_out), 'h30);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all expected declarations seen", exp_q.size(), 0);

        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule